// File: doc/BRIEF.md
# Two-Wire Bus Stuck-Line Recovery Sequencer

This block frees a two-wire serial bus when a target device is holding the data line low, for example after a transfer was cut off part way through. It takes control of both bus lines through two override enables. When an override enable is 1, the matching open-drain line is pulled low. When it is 0, the line is left to its pull-up. The block first toggles the clock line nine times, which is enough to let any target finish the byte it was sending. It then builds a STOP condition: the data line is held low while the clock is low, the clock line is released next, and the data line is released last.

A single-cycle start request launches the sequence. Every step lasts one phase, and the phase length is a parameter that gives the number of system clocks in 5 µs. When the last phase ends, the block raises a one-clock completion pulse and returns to idle with both overrides off. The block does not decide when the bus is stuck, and it does not drive normal transfers. Both of those jobs belong to the surrounding controller.

Top module: `bus_clear_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `scl_ovr`, `sda_ovr` and `done` are all 0.
- R2: Each step of the sequence holds its output values for exactly `PHASE_CLKS` clock cycles. The first step starts in the cycle after the clock edge at which `start` is sampled high.
- R3: The sequence begins with `NUM_PULSES` (default 9) clock pulses, with `sda_ovr` held at 0 throughout. Each pulse is one phase with `scl_ovr`=0 followed by one phase with `scl_ovr`=1.
- R4: After the last pulse, `sda_ovr` becomes 1 while `scl_ovr` stays 1, and this holds for one phase.
- R5: Next, `scl_ovr` returns to 0 while `sda_ovr` stays 1, for one phase. This releases the clock line before the data line.
- R6: Next, both overrides are 0 for one phase. `done` is then 1 for exactly one cycle, and the block is idle in that cycle.
- R7: A `start` pulse that arrives while a sequence is running has no effect on the outputs.
- R8: A `start` sampled high in the cycle where `done` is 1 begins a new sequence at once, with no extra idle cycle.
- R9: A synchronous reset asserted in the middle of a sequence returns all outputs to 0 in the cycle after the reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to run the recovery sequence; honoured only when idle |
| scl_ovr | output | 1 | Clock-line override; 1 pulls the clock line low |
| sda_ovr | output | 1 | Data-line override; 1 pulls the data line low |
| done | output | 1 | One-cycle pulse when the sequence has finished |

## Verification
Two events can fall in the same cycle: the completion pulse, and the acceptance of a new start request. Both happen at the idle boundary. To provoke this, `start` is held high across an entire sequence. The request is therefore ignored while the sequence runs, and it is sampled again in the very cycle that `done` is high. The scoreboard expects the first sequence, then the one-cycle `done`, and then the second sequence's first phase straight away, with no idle cycle between them. The same held request also confirms that mid-sequence requests leave the output pattern unchanged.

// File: rtl/bus_clear_pkg.sv
package bus_clear_pkg;
  // Steps of the recovery sequence
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_CLK_REL  = 3'd1,  // clock released (first half of a pulse)
    ST_CLK_LOW  = 3'd2,  // clock pulled low (second half of a pulse)
    ST_DATA_LOW = 3'd3,  // data pulled low under a low clock
    ST_CLK_FREE = 3'd4,  // clock released, data still low
    ST_ALL_FREE = 3'd5   // both lines released
  } clr_state_t;
endpackage

// File: rtl/clr_phase_timer.sv
module clr_phase_timer #(
  parameter int PHASE_CLKS = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PHASE_CLKS - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/clr_pulse_counter.sv
module clr_pulse_counter #(
  parameter int NUM_PULSES = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int PW = (NUM_PULSES > 1) ? $clog2(NUM_PULSES) : 1;
  localparam logic [PW-1:0] FINAL = PW'(NUM_PULSES - 1);

  logic [PW-1:0] cnt;

  assign last = (cnt == FINAL);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bus_clear_seq.sv
module bus_clear_seq
  import bus_clear_pkg::*;
#(
  parameter int PHASE_CLKS = 250,
  parameter int NUM_PULSES = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic scl_ovr,
  output logic sda_ovr,
  output logic done
);
  clr_state_t state, state_nxt;
  logic       tick, last_pulse, pulse_inc, running;

  assign running   = (state != ST_IDLE);
  assign pulse_inc = tick && (state == ST_CLK_LOW);

  clr_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) u_timer (
    .clk (clk),
    .rst (rst),
    .run (running),
    .tick(tick)
  );

  clr_pulse_counter #(.NUM_PULSES(NUM_PULSES)) u_pulses (
    .clk (clk),
    .rst (rst),
    .clr (!running),
    .inc (pulse_inc),
    .last(last_pulse)
  );

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE:     if (start) state_nxt = ST_CLK_REL;
      ST_CLK_REL:  if (tick)  state_nxt = ST_CLK_LOW;
      ST_CLK_LOW:  if (tick)  state_nxt = last_pulse ? ST_DATA_LOW : ST_CLK_REL;
      ST_DATA_LOW: if (tick)  state_nxt = ST_CLK_FREE;
      ST_CLK_FREE: if (tick)  state_nxt = ST_ALL_FREE;
      ST_ALL_FREE: if (tick)  state_nxt = ST_IDLE;
      default:                state_nxt = ST_IDLE;
    endcase
  end

  // Outputs are registered together with the state they belong to
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      scl_ovr <= 1'b0;
      sda_ovr <= 1'b0;
      done    <= 1'b0;
    end else begin
      state   <= state_nxt;
      scl_ovr <= (state_nxt == ST_CLK_LOW) || (state_nxt == ST_DATA_LOW);
      sda_ovr <= (state_nxt == ST_DATA_LOW) || (state_nxt == ST_CLK_FREE);
      done    <= (state == ST_ALL_FREE) && tick;
    end
  end
endmodule

// File: rtl/bus_clear_seq_chk.sv
module bus_clear_seq_chk #(
  parameter int NUM_PULSES = 9
) (
  input logic clk,
  input logic rst,
  input logic scl_ovr,
  input logic sda_ovr,
  input logic done
);
  logic       scl_q;
  logic [7:0] rise_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q    <= 1'b0;
      rise_cnt <= '0;
    end else begin
      scl_q <= scl_ovr;
      if (done)                  rise_cnt <= '0;
      else if (scl_ovr && !scl_q) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  // R3
  pulse_count_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_ovr) |-> (rise_cnt == 8'(NUM_PULSES)));
  // R4
  data_under_low_clk_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_ovr) |-> scl_ovr);
  // R5
  clk_before_data_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_ovr) |-> !scl_ovr);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!scl_ovr && !sda_ovr));
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!scl_ovr && !sda_ovr && !done));
endmodule

bind bus_clear_seq bus_clear_seq_chk #(.NUM_PULSES(NUM_PULSES)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .scl_ovr(scl_ovr),
  .sda_ovr(sda_ovr),
  .done   (done)
);

// File: tb/bus_clear_seq_test.sv
module bus_clear_seq_test;
  localparam int PH = 4;
  localparam int NP = 9;
  localparam int SEQ_LEN = (2 * NP + 3) * PH;

  typedef struct {
    logic  scl;
    logic  sda;
    logic  dn;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic scl_ovr, sda_ovr, done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;

  bus_clear_seq #(.PHASE_CLKS(PH), .NUM_PULSES(NP)) uut (
    .clk(clk), .rst(rst), .start(start),
    .scl_ovr(scl_ovr), .sda_ovr(sda_ovr), .done(done)
  );

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {scl,sda,done} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(logic s, logic d, logic dn, string tag, int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.scl = s; e.sda = d; e.dn = dn; e.tag = tag;
      q.push_back(e);
    end
  endtask

  task automatic push_seq();
    for (int p = 0; p < NP; p++) begin
      push(1'b0, 1'b0, 1'b0, "R3 released half (R2 length)", PH);
      push(1'b1, 1'b0, 1'b0, "R3 low half (R2 length)", PH);
    end
    push(1'b1, 1'b1, 1'b0, "R4 data low under low clock", PH);
    push(1'b0, 1'b1, 1'b0, "R5 clock released first", PH);
    push(1'b0, 1'b0, 1'b0, "R6 both released", PH);
    push(1'b0, 1'b0, 1'b1, "R6 done pulse", 1);
  endtask

  // Monitor: compare one expected item per cycle, away from the edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, {scl_ovr, sda_ovr, done}, {e.scl, e.sda, e.dn});
    end
  end

  task automatic wait_drain();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", {scl_ovr, sda_ovr, done}, 3'b000);
    #1 rst = 1'b0;
    push(1'b0, 1'b0, 1'b0, "R1 idle", 5);
    wait_drain();

    // Single run with a one-cycle start
    #1;
    push_seq();
    push(1'b0, 1'b0, 1'b0, "R1 idle after run", 4);
    start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
    wait_drain();

    // Start pulses during a run are ignored (R7)
    #1;
    push_seq();
    push(1'b0, 1'b0, 1'b0, "R7 idle after run", 4);
    start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
    repeat (10) @(negedge clk);
    #1 start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
    repeat (2 * NP * PH) @(negedge clk);
    #1 start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
    wait_drain();

    // Start held through done: back-to-back run (R8)
    #1;
    push_seq();
    push(1'b0, 1'b0, 1'b0, "R8 restart in done cycle", PH);
    q.pop_back();
    for (int i = 0; i < PH; i++) void'(q.pop_back());
    push(1'b0, 1'b0, 1'b1, "R8 done of first run", 1);
    push_seq();
    push(1'b0, 1'b0, 1'b0, "R8 idle after second run", 4);
    start = 1'b1;
    repeat (SEQ_LEN + 2) @(negedge clk);
    #1 start = 1'b0;
    wait_drain();

    // Reset in the middle of a run (R9)
    #1 start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
    repeat (PH + 2) @(negedge clk);
    check("R9 run in progress", {scl_ovr, sda_ovr, done}, 3'b100);
    #1 rst = 1'b1;
    @(negedge clk);
    check("R9 outputs cleared by reset", {scl_ovr, sda_ovr, done}, 3'b000);
    #1 rst = 1'b0;
    push(1'b0, 1'b0, 1'b0, "R9 stays idle after reset", 3 * PH);
    wait_drain();

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule